// File: doc/BRIEF.md
# Strap-Selectable Device Interrupt Request Generator

This block sits inside a peripheral and turns the state of its control/status register into a single interrupt request line toward the system bus. The register carries four meaningful bits: an error summary and a ready flag that the device's own status logic drives, and an interrupt enable and a start (go) bit that software writes. When the qualifying condition makes a 0-to-1 transition, a request latch is set. The latch is cleared when the device is initialized or when the bus acknowledges the interrupt.

A two-bit strap picks one of three gating behaviours. The first is a masked form, where the latch is set by the rising edge of ready-and-enable and the output is hidden whenever either bit is low. The second is a ready-clocked form, where the latch loads the enable bit on each rising edge of ready and only enable masks the output. The third is an unmaskable form, where the latch is set like the masked form but drives the line directly, so software cannot take the request back.

All inputs are sampled on the system clock. Ready and error are registered once. Edges are found by comparing the registered values with the values from the previous cycle.

Top module: `csr_irq_gen`

## Requirements
- R1: A CSR read returns the error summary at bit 15, ready at bit 6+1 (bit 7), enable at bit 6 and go at bit 0, and zero in every other bit. The ready and error bits show the `stat_ready` and `stat_error` inputs as they were at the previous clock edge.
- R2: A CSR write loads only the enable bit (bit 6) and the go bit (bit 0) from the write data. The ready, error and reserved bits are unaffected by writes. Without a write, enable and go hold their values.
- R3: In every mode, `dev_init` or `irq_ack` high during a cycle clears the request latch at that cycle's closing edge, so `irq_req` is low in the next cycle. This holds even when a set condition arrives in the same cycle.
- R4: In masked mode (strap 00), the latch sets one clock after ready-and-enable, as seen in the CSR, goes from 0 to 1. Setting enable while ready is already 1 therefore raises a request.
- R5: In masked mode, `irq_req` is the latch ANDed with the CSR ready and enable bits. Dropping either bit lowers the line.
- R6: In ready-clocked mode (strap 01), the latch loads the enable bit one clock after each rising edge of CSR ready. A rising edge with enable low empties the latch. Setting enable alone never sets it.
- R7: In ready-clocked mode, `irq_req` is the latch ANDed with enable only. Dropping ready neither clears nor hides a latched request. Clearing enable hides it, and setting enable again exposes it.
- R8: In unmaskable mode (strap 10), the latch sets on the rising edge of ready-and-enable and drives `irq_req` directly. Clearing ready or enable leaves the request high until R3 clears it.
- R9: Strap value 11 behaves exactly as masked mode.
- R10: While `rst_n` is low, the CSR reads zero and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_sel | input | 2 | Static strap: 00 masked, 01 ready-clocked, 10 unmaskable, 11 masked |
| stat_ready | input | 1 | Device ready status |
| stat_error | input | 1 | Device error summary status |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_data | input | 16 | CSR write data |
| csr_rd_data | output | 16 | CSR read value |
| dev_init | input | 1 | Device initialization, clears the request |
| irq_ack | input | 1 | Bus interrupt acknowledge, clears the request |
| irq_req | output | 1 | Interrupt request line |

## Verification
On every cycle, the assertions check the following:
- the CSR read layout and that reserved bits read zero;
- that ready and error follow their inputs and that software writes reach only enable and go;
- that a clear always leaves the line low in the next cycle;
- the output masking of the masked and ready-clocked modes, including strap 11;
- that an unmaskable request holds until it is cleared.

When a request is born, and what the latch holds while it is masked, can only be shown by the bench's scenarios. These scenarios cover:
- enable raised while ready is already high;
- a ready edge with enable low emptying the latch;
- a request hidden and then revealed by enable;
- a set and a clear that collide in the same cycle.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;

    typedef enum logic [1:0] {
        GATE_MASKED    = 2'b00,
        GATE_RDY_CLOCK = 2'b01,
        GATE_UNMASKED  = 2'b10,
        GATE_MASKED_B  = 2'b11
    } gate_mode_e;

    typedef struct packed {
        logic ready;
        logic cond;
    } edge_hist_t;

    // Strap value 11 is folded onto the masked behaviour.
    function automatic gate_mode_e resolve_mode(input logic [1:0] strap);
        gate_mode_e m;
        case (strap)
            2'b01:   m = GATE_RDY_CLOCK;
            2'b10:   m = GATE_UNMASKED;
            default: m = GATE_MASKED;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irqgen_csr.sv
module irqgen_csr #(
    parameter int CSR_W   = 16,
    parameter int RDY_POS = 7,
    parameter int IE_POS  = 6,
    parameter int ERR_POS = 15,
    parameter int GO_POS  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_ready,
    input  logic             stat_error,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data,
    output logic             ready,
    output logic             enable
);
    localparam logic [CSR_W-1:0] WR_MASK =
        (CSR_W'(1) << IE_POS) | (CSR_W'(1) << GO_POS);

    typedef struct packed {
        logic [CSR_W-1:0] sw;     // software-writable image, non-mask bits stay zero
        logic             ready;
        logic             error;
    } csr_state_t;

    csr_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ready = stat_ready;
        st_d.error = stat_error;
        if (wr_en) begin
            st_d.sw = (st_q.sw & ~WR_MASK) | (wr_data & WR_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data          = st_q.sw;
        rd_data[RDY_POS] = st_q.ready;
        rd_data[ERR_POS] = st_q.error;
    end

    assign ready  = st_q.ready;
    assign enable = st_q.sw[IE_POS];

endmodule

// File: rtl/irqgen_edges.sv
module irqgen_edges
    import irqgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic enable,
    output logic ready_rise,
    output logic cond_rise
);
    edge_hist_t hist_d, hist_q;
    logic       cond_now;

    always_comb begin
        cond_now     = ready & enable;
        hist_d.ready = ready;
        hist_d.cond  = cond_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign ready_rise = ready & ~hist_q.ready;
    assign cond_rise  = cond_now & ~hist_q.cond;

endmodule

// File: rtl/irqgen_latch.sv
module irqgen_latch
    import irqgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gate_mode_e mode,
    input  logic       ready,
    input  logic       enable,
    input  logic       ready_rise,
    input  logic       cond_rise,
    input  logic       clear,
    output logic       req
);
    typedef struct packed {
        logic pend;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (mode)
            GATE_RDY_CLOCK: begin
                // flop clocked by ready: loads enable, may also empty itself
                if (ready_rise) st_d.pend = enable;
            end
            default: begin
                if (cond_rise) st_d.pend = 1'b1;
            end
        endcase
        if (clear) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (mode)
            GATE_RDY_CLOCK: req = st_q.pend & enable;
            GATE_UNMASKED:  req = st_q.pend;
            default:        req = st_q.pend & ready & enable;
        endcase
    end

endmodule

// File: rtl/csr_irq_gen.sv
module csr_irq_gen
    import irqgen_pkg::*;
#(
    parameter int CSR_W   = 16,
    parameter int RDY_POS = 7,
    parameter int IE_POS  = 6,
    parameter int ERR_POS = 15,
    parameter int GO_POS  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       variant_sel,
    input  logic             stat_ready,
    input  logic             stat_error,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wr_data,
    output logic [CSR_W-1:0] csr_rd_data,
    input  logic             dev_init,
    input  logic             irq_ack,
    output logic             irq_req
);
    gate_mode_e mode;
    logic       ready, enable, ready_rise, cond_rise, clear;

    assign mode  = resolve_mode(variant_sel);
    assign clear = dev_init | irq_ack;

    irqgen_csr #(
        .CSR_W  (CSR_W),
        .RDY_POS(RDY_POS),
        .IE_POS (IE_POS),
        .ERR_POS(ERR_POS),
        .GO_POS (GO_POS)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_ready(stat_ready),
        .stat_error(stat_error),
        .wr_en     (csr_wr_en),
        .wr_data   (csr_wr_data),
        .rd_data   (csr_rd_data),
        .ready     (ready),
        .enable    (enable)
    );

    irqgen_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .enable    (enable),
        .ready_rise(ready_rise),
        .cond_rise (cond_rise)
    );

    irqgen_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .ready     (ready),
        .enable    (enable),
        .ready_rise(ready_rise),
        .cond_rise (cond_rise),
        .clear     (clear),
        .req       (irq_req)
    );

endmodule

// File: rtl/irqgen_checker.sv
module irqgen_checker #(
    parameter int CSR_W   = 16,
    parameter int RDY_POS = 7,
    parameter int IE_POS  = 6,
    parameter int ERR_POS = 15,
    parameter int GO_POS  = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       variant_sel,
    input logic             stat_ready,
    input logic             stat_error,
    input logic             csr_wr_en,
    input logic             wr_ie,
    input logic             wr_go,
    input logic [CSR_W-1:0] csr_rd_data,
    input logic             dev_init,
    input logic             irq_ack,
    input logic             irq_req
);
    localparam logic [CSR_W-1:0] USED = (CSR_W'(1) << RDY_POS) | (CSR_W'(1) << IE_POS)
                                      | (CSR_W'(1) << ERR_POS) | (CSR_W'(1) << GO_POS);

    logic rd_rdy, rd_ie;
    assign rd_rdy = csr_rd_data[RDY_POS];
    assign rd_ie  = csr_rd_data[IE_POS];

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd_data & ~USED) == '0);                                             // R1
    AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rd_rdy == $past(stat_ready));                                    // R1
    AST_ERROR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> csr_rd_data[ERR_POS] == $past(stat_error));                      // R1
    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en |=> (rd_ie == $past(wr_ie)) && (csr_rd_data[GO_POS] == $past(wr_go))); // R2
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_en |=> $stable(rd_ie) && $stable(csr_rd_data[GO_POS]));          // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_init || irq_ack) |=> !irq_req);                                      // R3
    AST_MASKED_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_sel == 2'b00 && !(rd_rdy && rd_ie)) |-> !irq_req);              // R5
    AST_STRAP11_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_sel == 2'b11 && !(rd_rdy && rd_ie)) |-> !irq_req);              // R9
    AST_RDYCLK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_sel == 2'b01 && !rd_ie) |-> !irq_req);                          // R7
    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (variant_sel == 2'b10 && irq_req && !dev_init && !irq_ack) |=> irq_req); // R8

endmodule

bind csr_irq_gen irqgen_checker #(
    .CSR_W  (CSR_W),
    .RDY_POS(RDY_POS),
    .IE_POS (IE_POS),
    .ERR_POS(ERR_POS),
    .GO_POS (GO_POS)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .variant_sel(variant_sel),
    .stat_ready (stat_ready),
    .stat_error (stat_error),
    .csr_wr_en  (csr_wr_en),
    .wr_ie      (csr_wr_data[IE_POS]),
    .wr_go      (csr_wr_data[GO_POS]),
    .csr_rd_data(csr_rd_data),
    .dev_init   (dev_init),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req)
);

// File: tb/csr_irq_gen_test.sv
`timescale 1ns/1ps
module csr_irq_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  variant_sel = 2'b00;
    logic        stat_ready = 1'b0, stat_error = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [15:0] csr_wr_data = '0;
    logic [15:0] csr_rd_data;
    logic        dev_init = 1'b0, irq_ack = 1'b0;
    logic        irq_req;

    int    n_checks = 0, n_fail = 0;
    string cur_req = "R10";
    bit    cmp_on = 1'b0;

    // behavioural reference state
    bit m_rdy, m_err, m_ie, m_go, m_prev_rdy, m_prev_both, m_pend;

    always #4 clk = ~clk;

    csr_irq_gen uut (
        .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel),
        .stat_ready(stat_ready), .stat_error(stat_error),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
        .dev_init(dev_init), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_rdy, m_err, m_ie, m_go, m_prev_rdy, m_prev_both, m_pend} = '0;
        end else begin
            bit both, nxt;
            both = m_rdy && m_ie;
            nxt  = m_pend;
            if (variant_sel == 2'b01) begin
                if (m_rdy && !m_prev_rdy) nxt = m_ie;
            end else if (both && !m_prev_both) begin
                nxt = 1'b1;
            end
            if (dev_init || irq_ack) nxt = 1'b0;
            m_prev_rdy  = m_rdy;
            m_prev_both = both;
            m_pend      = nxt;
            m_rdy       = stat_ready;
            m_err       = stat_error;
            if (csr_wr_en) begin
                m_ie = csr_wr_data[6];
                m_go = csr_wr_data[0];
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [15:0] exp_rd;
            logic        exp_irq;
            exp_rd = '0;
            exp_rd[15] = m_err; exp_rd[7] = m_rdy; exp_rd[6] = m_ie; exp_rd[0] = m_go;
            case (variant_sel)
                2'b01:   exp_irq = m_pend && m_ie;
                2'b10:   exp_irq = m_pend;
                default: exp_irq = m_pend && m_rdy && m_ie;
            endcase
            check(csr_rd_data, exp_rd, cur_req, "model csr");
            check({15'd0, irq_req}, {15'd0, exp_irq}, cur_req, "model irq");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic csr_write(input logic [15:0] d);
        csr_wr_en = 1'b1; csr_wr_data = d;
        @(negedge clk);
        csr_wr_en = 1'b0; csr_wr_data = '0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic restart(input logic [1:0] strap);
        rst_n = 1'b0; stat_ready = 1'b0; stat_error = 1'b0;
        variant_sel = strap;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic exp_irq(input logic e, input string req, input string what);
        check({15'd0, irq_req}, {15'd0, e}, req, what);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R10 reset state
        stat_ready = 1'b1; stat_error = 1'b1;
        tick(3);
        cmp_on = 1'b1;
        check(csr_rd_data, 16'h0000, "R10", "csr in reset");
        exp_irq(1'b0, "R10", "irq in reset");

        // masked mode
        restart(2'b00);
        cur_req = "R2";
        csr_write(16'hFFFF);
        tick(1);
        check(csr_rd_data, 16'h0041, "R2", "only enable and go written");
        cur_req = "R1";
        stat_error = 1'b1; tick(2);
        check(csr_rd_data, 16'h8041, "R1", "error bit placement");
        stat_error = 1'b0;
        cur_req = "R4";
        stat_ready = 1'b1; tick(2);
        exp_irq(1'b1, "R4", "ready rise with enable");
        cur_req = "R3";
        ack_pulse();
        exp_irq(1'b0, "R3", "ack clears");
        cur_req = "R4";
        csr_write(16'h0000); tick(2);
        csr_write(16'h0040); tick(1);
        exp_irq(1'b1, "R4", "enable set with ready high");
        cur_req = "R5";
        stat_ready = 1'b0; tick(1);
        exp_irq(1'b0, "R5", "ready low hides");
        stat_ready = 1'b1; tick(3);
        csr_write(16'h0000);
        exp_irq(1'b0, "R5", "enable low hides");
        cur_req = "R3";
        csr_write(16'h0040);         // rise seen at next edge
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        exp_irq(1'b0, "R3", "clear beats simultaneous set");
        tick(2);
        exp_irq(1'b0, "R3", "no late set after collision");

        // strap 11 as masked
        restart(2'b11);
        cur_req = "R9";
        csr_write(16'h0040);
        stat_ready = 1'b1; tick(2);
        exp_irq(1'b1, "R9", "strap 11 sets");
        stat_ready = 1'b0; tick(1);
        exp_irq(1'b0, "R9", "strap 11 masks by ready");
        dev_init = 1'b1; tick(1); dev_init = 1'b0;

        // ready-clocked mode
        restart(2'b01);
        cur_req = "R6";
        stat_ready = 1'b1; tick(2);
        csr_write(16'h0040); tick(2);
        exp_irq(1'b0, "R6", "enable alone never raises");
        stat_ready = 1'b0; tick(2);
        stat_ready = 1'b1; tick(2);
        exp_irq(1'b1, "R6", "ready edge loads enable");
        cur_req = "R7";
        stat_ready = 1'b0; tick(2);
        exp_irq(1'b1, "R7", "ready low does not hide");
        csr_write(16'h0000); tick(1);
        exp_irq(1'b0, "R7", "enable low hides");
        csr_write(16'h0040); tick(1);
        exp_irq(1'b1, "R7", "enable back exposes");
        cur_req = "R6";
        csr_write(16'h0000);
        stat_ready = 1'b1; tick(2);
        csr_write(16'h0040); tick(1);
        exp_irq(1'b0, "R6", "edge with enable low empties latch");
        cur_req = "R3";
        stat_ready = 1'b0; tick(2);
        stat_ready = 1'b1; tick(2);
        dev_init = 1'b1; tick(1); dev_init = 1'b0;
        exp_irq(1'b0, "R3", "init clears ready-clocked");

        // unmaskable mode
        restart(2'b10);
        cur_req = "R8";
        csr_write(16'h0040);
        stat_ready = 1'b1; tick(2);
        exp_irq(1'b1, "R8", "sets on rise");
        csr_write(16'h0000);
        stat_ready = 1'b0; tick(3);
        exp_irq(1'b1, "R8", "software cannot remove");
        cur_req = "R3";
        dev_init = 1'b1; tick(1); dev_init = 1'b0;
        exp_irq(1'b0, "R3", "init clears unmaskable");
        tick(3);

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule